// File: doc/BRIEF.md
# Paged MDIO-to-32-bit Register Bridge

This block sits behind an MDIO management slave that has already decoded the serial frames. It turns 16-bit register reads and writes, each given as a one-cycle strobe with a PHY number, a 5-bit register number and 16-bit data, into 32-bit word accesses on a simple internal register bus. Only one PHY number is answered; every other PHY number is left to other devices on the management bus.

A page register at MDIO register 31 holds the upper ten bits of the internal byte address. Registers 0 to 15 each stand for one 32-bit word within the current page and carry its low half. Register 16 carries the high half. Software writes the page, then the low half at the word's in-page register, then the high half at register 16. Writing register 16 commits the word. To read, software sets the page, reads the in-page register to get the low half, then reads register 16 to get the high half that the same access latched.

The internal bus is single-cycle. Bus strobes and the address are combinational from the MDIO strobe, and read data is sampled in that same cycle. The MDIO read result appears on `mdio_rdata` one clock after the read strobe and holds until the next read.

Top module: `mdio_reg_bridge`

## Requirements
- R1: Only strobes with `mdio_phy` equal to 31 have any effect. A read at any other PHY number returns 0xFFFF, and a write or read there causes no bus access and changes no state.
- R2: A write to register 31 loads the page from `mdio_wdata[9:0]` and ignores the upper data bits. A read of register 31 returns the page zero-extended to 16 bits. Reset sets the page to 0.
- R3: A write to register n (0 to 15) stores the data as the pending low half and captures the word address {page, n[3:0], 2'b00}. It issues no bus access.
- R4: A write to register 16 issues exactly one `bus_wr` pulse, in the same cycle as the strobe. The address is the one captured by the last low-half write, and `bus_wdata` is {written data, pending low half}.
- R5: A read of register n (0 to 15) issues exactly one `bus_rd` pulse at address {page, n[3:0], 2'b00} in the strobe cycle. One clock later, `mdio_rdata` shows `bus_rdata[15:0]`.
- R6: The same internal read latches `bus_rdata[31:16]`. A later read of register 16 returns that latched value, which is 0 after reset, and issues no bus access.
- R7: Registers 17 to 30 are unused. Reads of them return 0xFFFF, and writes to them cause no bus access and change no state.
- R8: The commit address is taken when the low half is written. Changing the page between the low-half write and the register 16 write does not move the commit.
- R9: After reset, `mdio_rdata` reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdio_wr | input | 1 | One-cycle decoded register write strobe |
| mdio_rd | input | 1 | One-cycle decoded register read strobe |
| mdio_phy | input | 5 | PHY number of the access |
| mdio_reg | input | 5 | Register number of the access |
| mdio_wdata | input | 16 | Write data |
| mdio_rdata | output | 16 | Read result, valid the cycle after `mdio_rd` |
| bus_wr | output | 1 | Internal 32-bit write request |
| bus_rd | output | 1 | Internal 32-bit read request |
| bus_addr | output | 16 | Internal byte address, word aligned |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data, sampled in the `bus_rd` cycle |

## Verification
The bench models the internal bus as a function of the address. Each word then carries a distinct upper and lower half, so a swapped half, a wrong page or a wrong in-page index shows up as a mismatch. Several sequences are used. Page, low write and commit go in the normal order, which checks address and data assembly. The page is changed between the low write and the commit, which separates captured-address from live-page behaviour. Register 16 is read twice, which shows it is a latch and not a new bus read. Foreign PHY numbers and the unused registers are mixed with page writes and then read back, which shows they leave no state behind. Any bus strobe the bench did not predict counts as a failure, so a stray access is caught.

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge #(
  parameter int PAGE_W   = 10,
  parameter int IDX_W    = 4,
  parameter int PHY_ID   = 31,
  parameter int PAGE_REG = 31,
  parameter int HI_REG   = 16,
  localparam int WORD_W  = PAGE_W + IDX_W,
  localparam int ADDR_W  = WORD_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_wr,
  input  logic              mdio_rd,
  input  logic [4:0]        mdio_phy,
  input  logic [4:0]        mdio_reg,
  input  logic [15:0]       mdio_wdata,
  output logic [15:0]       mdio_rdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);

  logic [PAGE_W-1:0] page_q;
  logic [WORD_W-1:0] cap_q;
  logic [15:0]       lo_q;
  logic [15:0]       hi_q;
  logic [15:0]       rd_mux;

  wire hit   = (mdio_phy == 5'(PHY_ID));
  wire is_lo = (mdio_reg < 5'(2 ** IDX_W));
  wire is_hi = (mdio_reg == 5'(HI_REG));
  wire is_pg = (mdio_reg == 5'(PAGE_REG));

  assign bus_rd    = rst_n & mdio_rd & hit & is_lo;
  assign bus_wr    = rst_n & mdio_wr & hit & is_hi;
  assign bus_addr  = is_hi ? {cap_q, 2'b00} : {page_q, mdio_reg[IDX_W-1:0], 2'b00};
  assign bus_wdata = {mdio_wdata, lo_q};

  always_comb begin
    rd_mux = 16'hFFFF;
    if (hit) begin
      if (is_lo)      rd_mux = bus_rdata[15:0];
      else if (is_hi) rd_mux = hi_q;
      else if (is_pg) rd_mux = 16'(page_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      cap_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      mdio_rdata <= 16'hFFFF;
    end else begin
      if (mdio_wr && hit) begin
        if (is_pg) page_q <= mdio_wdata[PAGE_W-1:0];
        else if (is_lo) begin
          lo_q  <= mdio_wdata;
          cap_q <= {page_q, mdio_reg[IDX_W-1:0]};
        end
      end
      if (mdio_rd) mdio_rdata <= rd_mux;
      if (bus_rd)  hi_q <= bus_rdata[31:16];
    end
  end

  a_r1_foreign_phy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_phy != 5'(PHY_ID)) |-> (!bus_rd && !bus_wr));

  a_r2_page_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_wr && hit && is_pg) |=> (page_q == $past(mdio_wdata[PAGE_W-1:0])));

  a_r5_low_return: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (mdio_rdata == $past(bus_rdata[15:0])));

  a_r6_high_latch: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (hi_q == $past(bus_rdata[31:16])));

  a_r7_gap_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_rd && hit && !is_lo && !is_hi && !is_pg) |=> (mdio_rdata == 16'hFFFF));

  a_r4_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

endmodule

// File: tb/mdio_reg_bridge_tb.sv
module mdio_reg_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_wr = 1'b0, mdio_rd = 1'b0;
  logic [4:0]  mdio_phy = 5'd0, mdio_reg = 5'd0;
  logic [15:0] mdio_wdata = 16'd0;
  logic [15:0] mdio_rdata;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  assign bus_rdata = {bus_addr ^ 16'hC3C3, ~bus_addr};

  mdio_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .mdio_wr(mdio_wr), .mdio_rd(mdio_rd),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_rdata(mdio_rdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  logic [48:0] ev_q[$];
  logic [15:0] rd_q[$];
  string       ev_tag[$];
  string       rd_tag[$];
  logic        rd_pend = 1'b0;

  task automatic check(input string req, input logic [48:0] act, input logic [48:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_pend) begin
      if (rd_q.size() == 0) check("R5 unexpected read result", 49'd1, 49'd0);
      else check(rd_tag.pop_front(), {33'd0, mdio_rdata}, {33'd0, rd_q.pop_front()});
    end
    rd_pend = mdio_rd;
    if (bus_wr || bus_rd) begin
      if (ev_q.size() == 0)
        check("R1/R7 unexpected bus access", {bus_wr, bus_addr, bus_wdata}, 49'd0);
      else if (bus_rd)
        check(ev_tag.pop_front(), {1'b0, bus_addr, 32'd0}, ev_q.pop_front());
      else
        check(ev_tag.pop_front(), {1'b1, bus_addr, bus_wdata}, ev_q.pop_front());
    end
  end

  task automatic mdio_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    mdio_phy = phy; mdio_reg = rg; mdio_wdata = d; mdio_wr = 1'b1;
    @(posedge clk); #1 mdio_wr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic mdio_read(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] exp, input string tag);
    rd_q.push_back(exp); rd_tag.push_back(tag);
    mdio_phy = phy; mdio_reg = rg; mdio_rd = 1'b1;
    @(posedge clk); #1 mdio_rd = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic expect_bus(input logic w, input logic [15:0] a, input logic [31:0] d, input string tag);
    ev_q.push_back({w, a, d}); ev_tag.push_back(tag);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset read value", {33'd0, mdio_rdata}, {33'd0, 16'hFFFF});
        @(posedge clk); #1;
        mdio_read(5'd31, 5'd31, 16'h0000, "R2 page after reset");
        mdio_read(5'd31, 5'd16, 16'h0000, "R6 high latch after reset");
        mdio_write(5'd31, 5'd31, 16'h02A5);
        mdio_read(5'd31, 5'd31, 16'h02A5, "R2 page readback");
        mdio_write(5'd31, 5'd31, 16'hFFFF);
        mdio_read(5'd31, 5'd31, 16'h03FF, "R2 page upper bits dropped");
        mdio_write(5'd31, 5'd5, 16'h1234);
        expect_bus(1'b1, 16'hFFD4, 32'hABCD1234, "R4 commit r3_capture");
        mdio_write(5'd31, 5'd16, 16'hABCD);
        mdio_write(5'd31, 5'd31, 16'h0001);
        mdio_write(5'd31, 5'd15, 16'hBEEF);
        mdio_write(5'd31, 5'd31, 16'h0002);
        expect_bus(1'b1, 16'h007C, 32'h5555BEEF, "R8 commit uses captured page");
        mdio_write(5'd31, 5'd16, 16'h5555);
        expect_bus(1'b0, 16'h009C, 32'd0, "R5 read address");
        mdio_read(5'd31, 5'd7, 16'hFF63, "R5 low half");
        mdio_read(5'd31, 5'd16, 16'hC35F, "R6 high half");
        mdio_read(5'd31, 5'd16, 16'hC35F, "R6 repeated high half no access");
        expect_bus(1'b0, 16'h0080, 32'd0, "R5 read address index 0");
        mdio_read(5'd31, 5'd0, 16'hFF7F, "R5 low half index 0");
        mdio_read(5'd31, 5'd16, 16'hC343, "R6 high half index 0");
        mdio_read(5'd5, 5'd3, 16'hFFFF, "R1 foreign phy read");
        mdio_read(5'd5, 5'd31, 16'hFFFF, "R1 foreign phy page read");
        mdio_write(5'd5, 5'd16, 16'h7777);
        mdio_write(5'd5, 5'd31, 16'h0011);
        mdio_write(5'd30, 5'd4, 16'h9999);
        mdio_read(5'd31, 5'd31, 16'h0002, "R1 page kept after foreign writes");
        mdio_read(5'd31, 5'd20, 16'hFFFF, "R7 unused register read");
        mdio_read(5'd31, 5'd17, 16'hFFFF, "R7 unused register 17 read");
        mdio_write(5'd31, 5'd20, 16'h0123);
        mdio_write(5'd31, 5'd30, 16'h0155);
        mdio_read(5'd31, 5'd31, 16'h0002, "R7 page kept after unused writes");
        expect_bus(1'b1, 16'h007C, 32'h6666BEEF, "R7 low half kept after unused writes");
        mdio_write(5'd31, 5'd16, 16'h6666);
        repeat (2) @(posedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        check("watchdog expired", 49'd1, 49'd0);
      end
    join_any
    #1;
    if (ev_q.size() != 0) check("R4/R5 missing bus access", 49'(ev_q.size()), 49'd0);
    if (rd_q.size() != 0) check("R5 missing read result", 49'(rd_q.size()), 49'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule